// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block sits beside a small microcontroller core and puts it to sleep. When the core executes its sleep instruction, a one-cycle strobe reaches the block. If the sleep-enable bit is set, the block records the 3-bit mode select and stops the clock domains that the mode calls for. It drives separate enables for the CPU, flash, I/O, ADC and asynchronous-timer domains, plus a run enable for the main oscillator. The two light modes also issue an ADC conversion-start pulse when the ADC is enabled.

While asleep, the block compares the wake-request vector with the set of sources that the current mode admits. The first admitted source, lowest index first, ends the sleep. The two modes that stop the oscillator do not resume at once: they hold the clocks off for a programmable stabilisation delay and keep the oscillator running during that delay. In those modes a level request on external line 0 must also stay high for a minimum number of cycles before it counts. When the clocks come back, the block gives a registered wake code and a one-cycle wake pulse, so the interrupt logic knows which source ended the sleep.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: Mode select 000 (light sleep) stops the CPU and flash clocks and keeps I/O, ADC, async-timer and oscillator running. Encodings 100 to 111 act exactly as 000. In this mode every wake source, indices 0 to 11, is admitted.
- R2: Mode select 001 (ADC quiet) stops the CPU, flash and I/O clocks and keeps ADC, async-timer and oscillator running. It admits only sources 0 to 9. Sources 10 (other internal interrupt) and 11 (other external interrupt) are ignored.
- R3: Mode select 010 (deep sleep) stops every clock and the oscillator. It admits only source 0 (external reset), 1 (watchdog reset), 2 (brown-out reset), 4 (serial start detect), 8 (line-0 level) and 9 (pin change).
- R4: Mode select 011 (timer sleep) behaves as 010, except for two things. The async-timer enable follows `tmr_on`. Source 5 (timer overflow) is admitted only when `tmr_ie[0]` and `gie` are both high, and source 6 (timer compare) only when `tmr_ie[1]` and `gie` are both high.
- R5: While asleep, a request that the current mode does not admit changes no output.
- R6: Entry into mode 000 (or 100 to 111) or mode 001 while `adc_en` is high gives `adc_start` high for exactly one cycle: the first cycle with the sleep clocks applied. Entry into modes 010 and 011 never gives it.
- R7: For modes 000 and 001, the clocks and the wake pulse return in the cycle after the first cycle in which an admitted request is sampled. For modes 010 and 011, they return `dly_cfg`+1 cycles later than that, with `osc_run` high and the CPU clock low in between.
- R8: In modes 010 and 011, the line-0 level request (source 8) is admitted only after it has been sampled high for LVL_HOLD consecutive cycles, and a shorter pulse is ignored. In modes 000 and 001, it is admitted at once.
- R9: A sleep strobe while `sleep_en` is low has no effect: all clocks stay enabled and no ADC start is issued.
- R10: On resume, `wake_pulse` is high for one cycle, in the first cycle the CPU clock is back, and `wake_code` gives the lowest-numbered admitted source that was pending when the wake was taken.
- R11: After reset, all clock enables and `osc_run` are high, and `adc_start`, `wake_pulse` and `wake_code` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_en | input | 1 | Sleep enable bit |
| sleep_strobe | input | 1 | One-cycle strobe from the sleep instruction |
| mode_sel | input | 3 | Sleep mode select |
| adc_en | input | 1 | ADC enabled |
| tmr_on | input | 1 | Async timer enabled |
| tmr_ie | input | 2 | Timer interrupt enables: bit 0 overflow, bit 1 compare |
| gie | input | 1 | Global interrupt enable |
| dly_cfg | input | DLY_W | Stabilisation delay in cycles (minus one) |
| wake_req | input | 12 | Wake requests, index = source number |
| cpu_clk_en | output | 1 | CPU clock enable |
| flash_clk_en | output | 1 | Flash clock enable |
| io_clk_en | output | 1 | I/O clock enable |
| adc_clk_en | output | 1 | ADC clock enable |
| asy_clk_en | output | 1 | Async-timer clock enable |
| osc_run | output | 1 | Main oscillator run enable |
| adc_start | output | 1 | ADC conversion-start pulse |
| wake_pulse | output | 1 | One-cycle wake pulse |
| wake_code | output | 4 | Source that ended the sleep |

## Verification
The mode filter and the priority encoder act in the same cycle. The bench raises several requests at once, some of which the mode rejects and one of which outranks the admitted source. It expects the wake code of the lowest admitted index, not the lowest raised index. It also provokes a line-0 level request that the hold counter is still qualifying in deep sleep, and checks that neither the stabilisation delay nor the pulse starts before the hold completes. A scoreboard records the exact cycle in which each wake pulse should appear and the code it should carry.

// File: rtl/slp_pkg.sv
package slp_pkg;

    localparam int WAKE_N = 12;
    localparam int CODE_W = $clog2(WAKE_N);

    // wake source indices (lower index = higher priority)
    localparam int SRC_EXT_RST  = 0;
    localparam int SRC_WDT_RST  = 1;
    localparam int SRC_BOD_RST  = 2;
    localparam int SRC_ADC_DONE = 3;
    localparam int SRC_SER_STRT = 4;
    localparam int SRC_TMR_OVF  = 5;
    localparam int SRC_TMR_CMP  = 6;
    localparam int SRC_MEM_RDY  = 7;
    localparam int SRC_LVL0     = 8;
    localparam int SRC_PIN_CHG  = 9;
    localparam int SRC_INT_OTH  = 10;
    localparam int SRC_EXT_OTH  = 11;

    typedef enum logic [2:0] {
        MD_LIGHT = 3'b000,
        MD_QUIET = 3'b001,
        MD_DEEP  = 3'b010,
        MD_TIMER = 3'b011
    } mode_e;

    typedef enum logic [1:0] {
        ST_ACTIVE   = 2'd0,
        ST_SLEEPING = 2'd1,
        ST_WAKE_DLY = 2'd2
    } state_e;

    typedef struct packed {
        logic cpu;
        logic flash;
        logic io;
        logic adc;
        logic asy;
        logic osc;
    } clk_en_t;

    function automatic mode_e norm_mode(input logic [2:0] raw);
        case (raw)
            3'b001:  return MD_QUIET;
            3'b010:  return MD_DEEP;
            3'b011:  return MD_TIMER;
            default: return MD_LIGHT;
        endcase
    endfunction

    function automatic logic osc_stops(input mode_e m);
        return (m == MD_DEEP) || (m == MD_TIMER);
    endfunction

    function automatic logic adc_autostart(input mode_e m);
        return (m == MD_LIGHT) || (m == MD_QUIET);
    endfunction

    function automatic logic [WAKE_N-1:0] accept_mask(
        input mode_e      m,
        input logic [1:0] t_ie,
        input logic       g_ie
    );
        logic [WAKE_N-1:0] msk;
        msk = '0;
        case (m)
            MD_LIGHT: msk = '1;
            MD_QUIET: begin
                for (int i = 0; i <= SRC_PIN_CHG; i++) msk[i] = 1'b1;
            end
            default: begin
                msk[SRC_EXT_RST]  = 1'b1;
                msk[SRC_WDT_RST]  = 1'b1;
                msk[SRC_BOD_RST]  = 1'b1;
                msk[SRC_SER_STRT] = 1'b1;
                msk[SRC_LVL0]     = 1'b1;
                msk[SRC_PIN_CHG]  = 1'b1;
                if (m == MD_TIMER) begin
                    msk[SRC_TMR_OVF] = t_ie[0] & g_ie;
                    msk[SRC_TMR_CMP] = t_ie[1] & g_ie;
                end
            end
        endcase
        return msk;
    endfunction

endpackage

// File: rtl/slp_wake_filt.sv
module slp_wake_filt
    import slp_pkg::*;
#(
    parameter int LVL_HOLD = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleeping,
    input  mode_e               mode,
    input  logic [1:0]          tmr_ie,
    input  logic                gie,
    input  logic [WAKE_N-1:0]   wake_req,
    output logic                hit,
    output logic [CODE_W-1:0]   hit_code
);
    localparam int CNT_W = $clog2(LVL_HOLD + 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LVL_HOLD - 1);

    logic [CNT_W-1:0]  lvl_cnt;
    logic [WAKE_N-1:0] mask;
    logic [WAKE_N-1:0] eff;
    logic              lvl_ok;

    // consecutive-high counter for the line-0 level request
    always_ff @(posedge clk) begin
        if (rst || !sleeping || !wake_req[SRC_LVL0]) begin
            lvl_cnt <= '0;
        end else if (lvl_cnt != CNT_TOP) begin
            lvl_cnt <= lvl_cnt + 1'b1;
        end
    end

    always_comb begin
        mask   = accept_mask(mode, tmr_ie, gie);
        lvl_ok = osc_stops(mode) ? (wake_req[SRC_LVL0] && lvl_cnt == CNT_TOP)
                                 : wake_req[SRC_LVL0];
        eff    = wake_req & mask;
        eff[SRC_LVL0] = mask[SRC_LVL0] & lvl_ok;
        hit    = sleeping & (|eff);
        hit_code = '0;
        for (int i = WAKE_N - 1; i >= 0; i--) begin
            if (eff[i]) hit_code = CODE_W'(i);
        end
    end

endmodule

// File: rtl/slp_fsm.sv
module slp_fsm
    import slp_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_en,
    input  logic                sleep_strobe,
    input  logic [2:0]          mode_sel,
    input  logic                adc_en,
    input  logic [DLY_W-1:0]    dly_cfg,
    input  logic                hit,
    input  logic [CODE_W-1:0]   hit_code,
    output state_e              state,
    output mode_e               mode,
    output logic                adc_start,
    output logic                wake_pulse,
    output logic [CODE_W-1:0]   wake_code
);
    logic [DLY_W-1:0]  dly_cnt;
    logic [CODE_W-1:0] pend_code;
    mode_e             req_mode;

    assign req_mode = norm_mode(mode_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_ACTIVE;
            mode       <= MD_LIGHT;
            dly_cnt    <= '0;
            pend_code  <= '0;
            adc_start  <= 1'b0;
            wake_pulse <= 1'b0;
            wake_code  <= '0;
        end else begin
            adc_start  <= 1'b0;
            wake_pulse <= 1'b0;
            case (state)
                ST_ACTIVE: begin
                    if (sleep_strobe && sleep_en) begin
                        mode      <= req_mode;
                        state     <= ST_SLEEPING;
                        adc_start <= adc_en && adc_autostart(req_mode);
                    end
                end
                ST_SLEEPING: begin
                    if (hit) begin
                        if (osc_stops(mode)) begin
                            state     <= ST_WAKE_DLY;
                            dly_cnt   <= dly_cfg;
                            pend_code <= hit_code;
                        end else begin
                            state      <= ST_ACTIVE;
                            wake_pulse <= 1'b1;
                            wake_code  <= hit_code;
                        end
                    end
                end
                ST_WAKE_DLY: begin
                    if (dly_cnt == '0) begin
                        state      <= ST_ACTIVE;
                        wake_pulse <= 1'b1;
                        wake_code  <= pend_code;
                    end else begin
                        dly_cnt <= dly_cnt - 1'b1;
                    end
                end
                default: state <= ST_ACTIVE;
            endcase
        end
    end

endmodule

// File: rtl/slp_clk_gate.sv
module slp_clk_gate
    import slp_pkg::*;
(
    input  state_e  state,
    input  mode_e   mode,
    input  logic    tmr_on,
    output clk_en_t en
);
    clk_en_t slp_en;

    always_comb begin
        case (mode)
            MD_LIGHT: slp_en = '{cpu: 1'b0, flash: 1'b0, io: 1'b1, adc: 1'b1, asy: 1'b1, osc: 1'b1};
            MD_QUIET: slp_en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b1, asy: 1'b1, osc: 1'b1};
            MD_TIMER: slp_en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asy: tmr_on, osc: 1'b0};
            default:  slp_en = '{cpu: 1'b0, flash: 1'b0, io: 1'b0, adc: 1'b0, asy: 1'b0, osc: 1'b0};
        endcase
        case (state)
            ST_SLEEPING: en = slp_en;
            ST_WAKE_DLY: begin
                en     = slp_en;
                en.osc = 1'b1;
            end
            default: en = '1;
        endcase
    end

endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
    import slp_pkg::*;
#(
    parameter int DLY_W    = 8,
    parameter int LVL_HOLD = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sleep_en,
    input  logic                sleep_strobe,
    input  logic [2:0]          mode_sel,
    input  logic                adc_en,
    input  logic                tmr_on,
    input  logic [1:0]          tmr_ie,
    input  logic                gie,
    input  logic [DLY_W-1:0]    dly_cfg,
    input  logic [WAKE_N-1:0]   wake_req,
    output logic                cpu_clk_en,
    output logic                flash_clk_en,
    output logic                io_clk_en,
    output logic                adc_clk_en,
    output logic                asy_clk_en,
    output logic                osc_run,
    output logic                adc_start,
    output logic                wake_pulse,
    output logic [CODE_W-1:0]   wake_code
);
    state_e            state;
    mode_e             mode;
    logic              hit;
    logic [CODE_W-1:0] hit_code;
    clk_en_t           en;

    slp_fsm #(.DLY_W(DLY_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .sleep_en     (sleep_en),
        .sleep_strobe (sleep_strobe),
        .mode_sel     (mode_sel),
        .adc_en       (adc_en),
        .dly_cfg      (dly_cfg),
        .hit          (hit),
        .hit_code     (hit_code),
        .state        (state),
        .mode         (mode),
        .adc_start    (adc_start),
        .wake_pulse   (wake_pulse),
        .wake_code    (wake_code)
    );

    slp_wake_filt #(.LVL_HOLD(LVL_HOLD)) u_filt (
        .clk      (clk),
        .rst      (rst),
        .sleeping (state == ST_SLEEPING),
        .mode     (mode),
        .tmr_ie   (tmr_ie),
        .gie      (gie),
        .wake_req (wake_req),
        .hit      (hit),
        .hit_code (hit_code)
    );

    slp_clk_gate u_gate (
        .state  (state),
        .mode   (mode),
        .tmr_on (tmr_on),
        .en     (en)
    );

    assign cpu_clk_en   = en.cpu;
    assign flash_clk_en = en.flash;
    assign io_clk_en    = en.io;
    assign adc_clk_en   = en.adc;
    assign asy_clk_en   = en.asy;
    assign osc_run      = en.osc;

endmodule

// File: rtl/slp_chk.sv
module slp_chk (
    input logic clk,
    input logic rst,
    input logic sleep_en,
    input logic sleep_strobe,
    input logic cpu_clk_en,
    input logic io_clk_en,
    input logic adc_clk_en,
    input logic osc_run,
    input logic adc_start,
    input logic wake_pulse
);
    // R9
    strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && sleep_strobe && !sleep_en) |=> cpu_clk_en);

    // R3
    osc_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !osc_run |-> (!cpu_clk_en && !io_clk_en && !adc_clk_en));

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |=> !wake_pulse);

    // R7
    resume_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> wake_pulse);

    // R10
    pulse_clk_chk: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> cpu_clk_en);

    // R6
    adc_start_ctx_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |-> (!cpu_clk_en && adc_clk_en));

    // R6
    adc_start_single_chk: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start);

endmodule

bind sleep_pwr_ctrl slp_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .sleep_en     (sleep_en),
    .sleep_strobe (sleep_strobe),
    .cpu_clk_en   (cpu_clk_en),
    .io_clk_en    (io_clk_en),
    .adc_clk_en   (adc_clk_en),
    .osc_run      (osc_run),
    .adc_start    (adc_start),
    .wake_pulse   (wake_pulse)
);

// File: tb/sim_sleep_pwr_ctrl.sv
module sim_sleep_pwr_ctrl;
    import slp_pkg::*;

    localparam int DLY_W    = 8;
    localparam int LVL_HOLD = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sleep_en = 1'b0, sleep_strobe = 1'b0, adc_en = 1'b0, tmr_on = 1'b0, gie = 1'b0;
    logic [2:0] mode_sel = '0;
    logic [1:0] tmr_ie = '0;
    logic [DLY_W-1:0] dly_cfg = '0;
    logic [WAKE_N-1:0] wake_req = '0;
    logic cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_run;
    logic adc_start, wake_pulse;
    logic [CODE_W-1:0] wake_code;

    int n_chk = 0, n_fail = 0, cyc = 0;

    typedef struct { int code; int at; } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sleep_pwr_ctrl #(.DLY_W(DLY_W), .LVL_HOLD(LVL_HOLD)) u0 (
        .clk(clk), .rst(rst), .sleep_en(sleep_en), .sleep_strobe(sleep_strobe),
        .mode_sel(mode_sel), .adc_en(adc_en), .tmr_on(tmr_on), .tmr_ie(tmr_ie),
        .gie(gie), .dly_cfg(dly_cfg), .wake_req(wake_req),
        .cpu_clk_en(cpu_clk_en), .flash_clk_en(flash_clk_en), .io_clk_en(io_clk_en),
        .adc_clk_en(adc_clk_en), .asy_clk_en(asy_clk_en), .osc_run(osc_run),
        .adc_start(adc_start), .wake_pulse(wake_pulse), .wake_code(wake_code)
    );

    function automatic logic [5:0] clkv();
        return {cpu_clk_en, flash_clk_en, io_clk_en, adc_clk_en, asy_clk_en, osc_run};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: pops expected wake items as pulses appear
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && wake_pulse) begin
                if (sb.size() == 0) begin
                    chk("R5", "unexpected wake pulse code", int'(wake_code), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk("R10", "wake code", int'(wake_code), e.code);
                    chk("R7", "wake pulse cycle", cyc, e.at);
                end
            end
        end
    end

    // enter sleep; vectors are {cpu,flash,io,adc,asy,osc}
    task automatic go_sleep(input logic [2:0] m, input logic en, input logic ae,
                            input logic [5:0] exp_clk, input logic exp_adc, input string req);
        mode_sel = m; sleep_en = en; adc_en = ae; sleep_strobe = 1'b1;
        @(negedge clk);
        sleep_strobe = 1'b0;
        chk(req, "sleep clock enables", int'(clkv()), int'(exp_clk));
        chk("R6", "adc start on entry", int'(adc_start), int'(exp_adc));
        @(negedge clk);
        chk("R6", "adc start after one cycle", int'(adc_start), 0);
    endtask

    // raise requests that must not wake; check core stays stopped
    task automatic no_wake(input logic [WAKE_N-1:0] rv, input int n, input string req);
        wake_req = rv;
        repeat (n) @(negedge clk);
        wake_req = '0;
        chk(req, "ignored request keeps cpu stopped", int'(cpu_clk_en), 0);
    endtask

    // raise requests that wake; h = cycles to qualify, osc = delay applies
    task automatic do_wake(input logic [WAKE_N-1:0] rv, input int code, input int h,
                           input bit osc, input string req);
        exp_t e;
        int d;
        d = osc ? int'(dly_cfg) + 1 : 0;
        e.code = code;
        e.at   = cyc + h + d;
        sb.push_back(e);
        wake_req = rv;
        repeat (h) @(negedge clk);
        if (osc) chk("R7", "delay window cpu/osc", int'({cpu_clk_en, osc_run}), 1);
        repeat (d + 1) @(negedge clk);
        wake_req = '0;
        chk(req, "clocks resumed", int'(clkv()), 6'h3F);
    endtask

    function automatic logic [WAKE_N-1:0] bitv(input int i);
        return WAKE_N'(1) << i;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        chk("R11", "reset clocks", int'(clkv()), 6'h3F);
        chk("R11", "reset pulses", int'({adc_start, wake_pulse}), 0);
        chk("R11", "reset wake code", int'(wake_code), 0);

        // R9: strobe with sleep disabled
        go_sleep(3'b000, 1'b0, 1'b1, 6'h3F, 1'b0, "R9");

        // R1: light sleep, any source
        go_sleep(3'b000, 1'b1, 1'b1, 6'h0F, 1'b1, "R1");
        do_wake(bitv(SRC_EXT_OTH), SRC_EXT_OTH, 1, 1'b0, "R1");

        // R1: reserved encoding acts as light sleep
        go_sleep(3'b110, 1'b1, 1'b1, 6'h0F, 1'b1, "R1");
        do_wake(bitv(SRC_INT_OTH), SRC_INT_OTH, 1, 1'b0, "R1");

        // R2: ADC quiet; other-ext ignored, filter then priority
        go_sleep(3'b001, 1'b1, 1'b0, 6'h07, 1'b0, "R2");
        no_wake(bitv(SRC_EXT_OTH) | bitv(SRC_INT_OTH), 4, "R2");
        do_wake(bitv(SRC_ADC_DONE) | bitv(SRC_SER_STRT) | bitv(SRC_EXT_OTH),
                SRC_ADC_DONE, 1, 1'b0, "R2");

        // R8: in ADC quiet, line-0 level wakes at once
        go_sleep(3'b001, 1'b1, 1'b1, 6'h07, 1'b1, "R2");
        do_wake(bitv(SRC_LVL0), SRC_LVL0, 1, 1'b0, "R8");

        // R3/R5: deep sleep with delay 5
        dly_cfg = 8'd5; tmr_ie = 2'b11; gie = 1'b1;
        go_sleep(3'b010, 1'b1, 1'b1, 6'h00, 1'b0, "R3");
        no_wake(bitv(SRC_TMR_OVF), 3, "R5");
        no_wake(bitv(SRC_ADC_DONE) | bitv(SRC_MEM_RDY), 3, "R5");
        do_wake(bitv(SRC_ADC_DONE) | bitv(SRC_PIN_CHG), SRC_PIN_CHG, 1, 1'b1, "R3");

        // R8: short level pulse ignored, full hold accepted
        go_sleep(3'b010, 1'b1, 1'b0, 6'h00, 1'b0, "R3");
        no_wake(bitv(SRC_LVL0), LVL_HOLD - 1, "R8");
        repeat (3) @(negedge clk);
        chk("R8", "short level pulse no wake", int'(cpu_clk_en), 0);
        do_wake(bitv(SRC_LVL0), SRC_LVL0, LVL_HOLD, 1'b1, "R8");

        // R4: timer sleep, delay 0
        dly_cfg = 8'd0; tmr_on = 1'b1;
        go_sleep(3'b011, 1'b1, 1'b1, 6'h02, 1'b0, "R4");
        tmr_ie = 2'b00; gie = 1'b1;
        no_wake(bitv(SRC_TMR_OVF), 3, "R4");
        tmr_ie = 2'b01; gie = 1'b0;
        no_wake(bitv(SRC_TMR_OVF), 3, "R4");
        tmr_ie = 2'b10; gie = 1'b1;
        no_wake(bitv(SRC_TMR_OVF), 3, "R4");
        do_wake(bitv(SRC_TMR_CMP), SRC_TMR_CMP, 1, 1'b1, "R4");

        // R10: reset sources outrank others
        go_sleep(3'b011, 1'b1, 1'b0, 6'h02, 1'b0, "R4");
        do_wake(bitv(SRC_WDT_RST) | bitv(SRC_PIN_CHG) | bitv(SRC_BOD_RST),
                SRC_WDT_RST, 1, 1'b1, "R10");

        repeat (4) @(negedge clk);
        chk("R10", "scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule